// File: doc/BRIEF.md
# Pulse Window Timer

A 16-bit timer block with two operating modes selected by a control bit. In timer mode a counter runs freely and is compared against a programmable compare value on every cycle. Equality raises a compare-match status flag. Match detection is suppressed for the one cycle in which a write to the compare value is committed, so a value being replaced cannot produce a spurious match.

In measurement mode the counter times an external input. The input is synchronized through two flip-flops. The first edge of a chosen polarity clears the counter. The opposite edge captures the pulse width. The next edge of the chosen polarity captures the full period and also starts the next measurement. The width capture is checked against an upper and a lower limit, and the period capture against an upper limit. Any violation sets a sticky status flag.

Software reaches the block through a simple word-addressed 16-bit register bus. Status flags can also be seen directly on a port. A single interrupt line is raised by any status flag whose enable bit is set.

Top module: `pulse_window_timer`

## Requirements
- R1: Register map by word address on `addr_i`: 0 control, 1 status, 2 compare, 3 width upper limit, 4 width lower limit, 5 period upper limit, 6 counter (read only), 7 capture (read only). Reads are combinational from `addr_i`. A write sampled with `we_i` high is committed in the following cycle, and its value reads back from the cycle after that.
- R2: After reset: control 0, status 0, counter 0, capture 0, compare 0xFFFF, width upper limit 0xFFFF, width lower limit 0x0000, period upper limit 0xFFFF.
- R3: The control register holds 6 bits. Bit 0 selects the mode (0 timer, 1 measurement). Bit 1 selects the starting-edge polarity (0 rising, 1 falling). Bits 5:2 enable the interrupt for status bits 3:0. Upper bits write as don't-care and read as 0.
- R4: In timer mode the counter adds one per cycle and wraps at 16 bits. A cycle in which counter equals compare sets status bit 0 at the next clock edge.
- R5: In the commit cycle of a write to the compare register, no compare match is detected.
- R6: In measurement mode, a starting edge seen while idle clears the counter. At the next opposite edge, the capture register receives the number of clock cycles between the two input transitions.
- R7: A width capture greater than the width upper limit sets status bit 1.
- R8: A width capture less than the width lower limit sets status bit 2.
- R9: The next starting edge captures the clock cycles elapsed since the previous starting edge and clears the counter for a new width measurement. A period capture greater than the period upper limit sets status bit 3.
- R10: Status bits are sticky. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A new event in the same cycle as the clear commit leaves the bit set.
- R11: `irq_o` is the OR over all status bits of each bit ANDed with its enable. `flags_o` always equals the status register.
- R12: With falling polarity selected, the low phase of the input is measured as the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| sig_i | input | 1 | Input signal to measure (asynchronous) |
| flags_o | output | 4 | Status flags: match, width over, width under, period over |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the bound assertions check the following: interrupt gating against the flags and enables, stickiness of the flags outside a status clear, the absence of a new compare match in the commit cycle of a compare write, the one-per-cycle counter step in timer mode, and that a rising limit flag always comes with a capture beyond the limit in force. The cycle-accurate reference model and the directed scenarios cover what a property cannot express locally. These are the actual capture values for widths and periods under both polarities, the reset values, the two-cycle write timing, and the exact coincidence of a flag clear with a new match.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int unsigned AW    = 3;
  localparam int unsigned NFLAG = 4;
  localparam int unsigned NLIM  = 4;

  typedef enum logic [AW-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_CMP  = 3'd2,
    A_WMAX = 3'd3,
    A_WMIN = 3'd4,
    A_PMAX = 3'd5,
    A_CNT  = 3'd6,
    A_CAP  = 3'd7
  } reg_addr_e;

  // flag bit positions
  localparam int unsigned F_MATCH = 0;
  localparam int unsigned F_WOVF  = 1;
  localparam int unsigned F_WUDF  = 2;
  localparam int unsigned F_POVF  = 3;

  // limit array slots, address = A_CMP + slot
  localparam int unsigned L_CMP  = 0;
  localparam int unsigned L_WMAX = 1;
  localparam int unsigned L_WMIN = 2;
  localparam int unsigned L_PMAX = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WIDTH,
    PH_PERIOD
  } phase_e;

  typedef struct packed {
    logic [NFLAG-1:0] en;
    logic             pol;
    logic             mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwc_sync_edge.sv
module pwc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-1:0], sig_i};
  end

  assign rise_o =  s_q[STAGES-1] & ~s_q[STAGES];
  assign fall_o = ~s_q[STAGES-1] &  s_q[STAGES];
endmodule

// File: rtl/pwc_regs.sv
module pwc_regs
  import pwc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output ctrl_t                     ctrl_o,
  output logic [NLIM-1:0][DW-1:0]   lim_o,
  output logic                      pend_o,
  output logic [AW-1:0]             pend_addr_o,
  output logic [DW-1:0]             pend_data_o
);
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  ctrl_t         ctrl_q;

  // phase one: latch the access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= we_i;
      if (we_i) begin
        pend_addr_q <= addr_i;
        pend_data_q <= wdata_i;
      end
    end
  end

  // phase two: commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_q <= '0;
    else if (pend_q && pend_addr_q == A_CTRL)     ctrl_q <= ctrl_t'(pend_data_q[CTRL_W-1:0]);
  end

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam logic [DW-1:0] RST = (g == L_WMIN) ? '0 : '1;
    localparam logic [AW-1:0] ADR = AW'(int'(A_CMP) + g);
    logic [DW-1:0] lim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lim_q <= RST;
      else if (pend_q && pend_addr_q == ADR)  lim_q <= pend_data_q;
    end
    assign lim_o[g] = lim_q;
  end

  assign ctrl_o      = ctrl_q;
  assign pend_o      = pend_q;
  assign pend_addr_o = pend_addr_q;
  assign pend_data_o = pend_data_q;
endmodule

// File: rtl/pwc_meas.sv
module pwc_meas
  import pwc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             cmp_block_i,
  input  logic [DW-1:0]    cmp_i,
  input  logic [DW-1:0]    wmax_i,
  input  logic [DW-1:0]    wmin_i,
  input  logic [DW-1:0]    pmax_i,
  output logic [DW-1:0]    cnt_o,
  output logic [DW-1:0]    cap_o,
  output logic [NFLAG-1:0] set_o
);
  logic [DW-1:0]    cnt_q, cnt_d, cnt_inc, cap_q, cap_d;
  phase_e           ph_q, ph_d;
  logic             start_edge, stop_edge;
  logic [NFLAG-1:0] set;

  assign cnt_inc    = cnt_q + 1'b1;
  assign start_edge = pol_i ? fall_i : rise_i;
  assign stop_edge  = pol_i ? rise_i : fall_i;

  always_comb begin
    cnt_d = cnt_inc;
    cap_d = cap_q;
    ph_d  = ph_q;
    set   = '0;
    if (!mode_i) begin
      ph_d = PH_IDLE;
      if (cnt_q == cmp_i && !cmp_block_i) set[F_MATCH] = 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_edge) begin
            cnt_d = '0;
            ph_d  = PH_WIDTH;
          end
        end
        PH_WIDTH: begin
          if (stop_edge) begin
            cap_d        = cnt_inc;
            set[F_WOVF]  = cnt_inc > wmax_i;
            set[F_WUDF]  = cnt_inc < wmin_i;
            ph_d         = PH_PERIOD;
          end
        end
        PH_PERIOD: begin
          if (start_edge) begin
            cap_d       = cnt_inc;
            set[F_POVF] = cnt_inc > pmax_i;
            cnt_d       = '0;
            ph_d        = PH_WIDTH;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
      ph_q  <= PH_IDLE;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      ph_q  <= ph_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign set_o = set;
endmodule

// File: rtl/pwc_status.sv
module pwc_status
  import pwc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [NFLAG-1:0] keep_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] en_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flags_q, flags_d;

  // set wins over a coincident clear
  always_comb begin
    flags_d = clr_en_i ? (flags_q & keep_i) : flags_q;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/pulse_window_timer.sv
module pulse_window_timer
  import pwc_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             sig_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  ctrl_t                    ctrl_q;
  logic [NLIM-1:0][DW-1:0]  lim;
  logic                     pend_q;
  logic [AW-1:0]            pend_addr_q;
  logic [DW-1:0]            pend_data_q;
  logic                     rise, fall, cmp_block, clr_en;
  logic [DW-1:0]            cnt_q, cap_q;
  logic [NFLAG-1:0]         set;
  logic [1:0]               lim_sel;

  pwc_regs #(.DW(DW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl_q),
    .lim_o      (lim),
    .pend_o     (pend_q),
    .pend_addr_o(pend_addr_q),
    .pend_data_o(pend_data_q)
  );

  pwc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cmp_block = pend_q && pend_addr_q == A_CMP;
  assign clr_en    = pend_q && pend_addr_q == A_STAT;

  pwc_meas #(.DW(DW)) i_meas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (ctrl_q.mode),
    .pol_i      (ctrl_q.pol),
    .rise_i     (rise),
    .fall_i     (fall),
    .cmp_block_i(cmp_block),
    .cmp_i      (lim[L_CMP]),
    .wmax_i     (lim[L_WMAX]),
    .wmin_i     (lim[L_WMIN]),
    .pmax_i     (lim[L_PMAX]),
    .cnt_o      (cnt_q),
    .cap_o      (cap_q),
    .set_o      (set)
  );

  pwc_status i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_en_i(clr_en),
    .keep_i  (pend_data_q[NFLAG-1:0]),
    .set_i   (set),
    .en_i    (ctrl_q.en),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign lim_sel = 2'(addr_i - AW'(A_CMP));

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CTRL:  rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  rdata_o = {{(DW-NFLAG){1'b0}}, flags_o};
      A_CNT:   rdata_o = cnt_q;
      A_CAP:   rdata_o = cap_q;
      default: rdata_o = lim[lim_sel];
    endcase
  end
endmodule

// File: rtl/pulse_window_timer_chk.sv
module pulse_window_timer_chk
  import pwc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NFLAG-1:0] flags_i,
  input logic             irq_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic             pend_i,
  input logic [AW-1:0]    pend_addr_i,
  input logic [DW-1:0]    cnt_i,
  input logic [DW-1:0]    cap_i,
  input logic [DW-1:0]    wmax_i,
  input logic [DW-1:0]    wmin_i,
  input logic [DW-1:0]    pmax_i
);
  assert_irq_gating_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == |(flags_i & ctrl_i[CTRL_W-1:2]));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_i && pend_addr_i == A_STAT) |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  assert_match_inhibit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && pend_i && pend_addr_i == A_CMP && !flags_i[F_MATCH]) |=> !flags_i[F_MATCH]);

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_width_over_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[F_WOVF]) |-> cap_i > $past(wmax_i));

  assert_width_under_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[F_WUDF]) |-> cap_i < $past(wmin_i));

  assert_period_over_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[F_POVF]) |-> cap_i > $past(pmax_i));
endmodule

bind pulse_window_timer pulse_window_timer_chk #(.DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flags_i    (flags_o),
  .irq_i      (irq_o),
  .ctrl_i     (ctrl_q),
  .pend_i     (pend_q),
  .pend_addr_i(pend_addr_q),
  .cnt_i      (cnt_q),
  .cap_i      (cap_q),
  .wmax_i     (lim[1]),
  .wmin_i     (lim[2]),
  .pmax_i     (lim[3])
);

// File: tb/test_pulse_window_timer.sv
module test_pulse_window_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sig = 1'b0;
  logic [3:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_window_timer i_pulse_window_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sig_i(sig), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_ctrl, m_flags, m_cnt, m_cap;
  int unsigned m_lim[4];
  int          m_phase;
  bit          m_pend;
  int unsigned m_paddr, m_pdata;
  bit          hist[$];

  task automatic model_reset();
    m_ctrl = 0; m_flags = 0; m_cnt = 0; m_cap = 0; m_phase = 0;
    m_lim = '{32'hFFFF, 32'hFFFF, 32'h0, 32'hFFFF};
    m_pend = 0; m_paddr = 0; m_pdata = 0;
    hist = '{1'b0, 1'b0, 1'b0};
  endtask

  task automatic model_step();
    bit syn = hist[1];
    bit prv = hist[2];
    bit up = syn && !prv;
    bit dn = !syn && prv;
    bit pol = m_ctrl[1];
    bit act = pol ? dn : up;
    bit inact = pol ? up : dn;
    int unsigned nxt = (m_cnt + 1) & 32'hFFFF;
    int unsigned newc = nxt;
    int unsigned set = 0;
    if (m_ctrl[0] == 1'b0) begin
      m_phase = 0;
      if (m_cnt == m_lim[0] && !(m_pend && m_paddr == 2)) set |= 1;
    end else if (m_phase == 0 && act) begin
      newc = 0; m_phase = 1;
    end else if (m_phase == 1 && inact) begin
      m_cap = nxt;
      if (nxt > m_lim[1]) set |= 2;
      if (nxt < m_lim[2]) set |= 4;
      m_phase = 2;
    end else if (m_phase == 2 && act) begin
      m_cap = nxt;
      if (nxt > m_lim[3]) set |= 8;
      newc = 0; m_phase = 1;
    end
    m_cnt = newc;
    if (m_pend && m_paddr == 1) m_flags &= (m_pdata & 32'hF);
    m_flags |= set;
    if (m_pend) begin
      if (m_paddr == 0) m_ctrl = m_pdata & 32'h3F;
      else if (m_paddr >= 2 && m_paddr <= 5) m_lim[m_paddr-2] = m_pdata;
    end
    m_pend = we; m_paddr = addr; m_pdata = wdata;
    hist.push_front(sig);
    void'(hist.pop_back());
  endtask

  function automatic int unsigned exp_rd(int unsigned a);
    case (a)
      0: return m_ctrl;
      1: return m_flags;
      6: return m_cnt;
      7: return m_cap;
      default: return m_lim[a-2];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      chk("R10 flags vs model", flags, m_flags);
      chk("R11 irq vs model", irq, |(m_flags[3:0] & m_ctrl[5:2]));
      chk("R1 rdata vs model", rdata, exp_rd(addr));
    end
  end

  // ---------------- bus and stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1; v = rdata;
  endtask

  // fire a write so that its commit cycle is the cycle with counter == k
  task automatic wr_at_count(input int k, input logic [2:0] a, input logic [15:0] d);
    logic [15:0] c;
    rd(3'd6, c);
    repeat (k - int'(c)) @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  bit   act_lvl;
  bit   have_prev;
  int   prev_period;
  logic [3:0] exp_f;
  int   lim_wmax, lim_wmin, lim_pmax;
  string pfx;

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); sig = act_lvl;
    repeat (4) @(negedge clk);
    if (have_prev) begin
      chk({pfx, " R9 period capture"}, rdata, prev_period);
      if (prev_period > lim_pmax) exp_f[3] = 1'b1;
    end
    repeat (hi - 4) @(negedge clk); sig = !act_lvl;
    repeat (4) @(negedge clk);
    chk({pfx, " R6 width capture"}, rdata, hi);
    if (hi > lim_wmax) exp_f[1] = 1'b1;
    if (hi < lim_wmin) exp_f[2] = 1'b1;
    chk({pfx, " R7 R8 R9 limit flags"}, flags & 4'hE, exp_f);
    repeat (lo - 5) @(negedge clk);
    prev_period = hi + lo;
    have_prev = 1;
  endtask

  initial begin
    logic [15:0] v, c1, c2;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    rd(3'd0, v); chk("R2 control reset", v, 16'h0000);
    rd(3'd1, v); chk("R2 status reset", v, 16'h0000);
    rd(3'd2, v); chk("R2 compare reset", v, 16'hFFFF);
    rd(3'd3, v); chk("R2 width upper reset", v, 16'hFFFF);
    rd(3'd4, v); chk("R2 width lower reset", v, 16'h0000);
    rd(3'd5, v); chk("R2 period upper reset", v, 16'hFFFF);
    rd(3'd7, v); chk("R2 capture reset", v, 16'h0000);
    chk("R2 irq reset", irq, 1'b0);

    // R4 counter step and compare match
    rd(3'd6, c1); rd(3'd6, c2);
    chk("R4 counter step", c2, c1 + 16'd1);
    wr(3'd2, 16'd300);
    repeat (320) @(negedge clk);
    chk("R4 match flag", flags[0], 1'b1);
    chk("R11 irq masked", irq, 1'b0);
    wr(3'd0, 16'hFFC4);
    rd(3'd0, v); chk("R3 control readback", v, 16'h0004);
    chk("R11 irq enabled", irq, 1'b1);
    wr(3'd1, 16'h0000);
    @(negedge clk);
    chk("R10 clear by zero", flags[0], 1'b0);
    chk("R11 irq after clear", irq, 1'b0);

    // R1 two-cycle write timing
    @(negedge clk); we = 1'b1; addr = 3'd4; wdata = 16'd7;
    @(posedge clk); #1; chk("R1 commit cycle old value", rdata, 16'd0);
    @(negedge clk); we = 1'b0;
    @(posedge clk); #1; chk("R1 new value visible", rdata, 16'd7);

    // R5 no match in compare commit cycle
    rd(3'd6, c1);
    k = int'(c1) + 40;
    wr(3'd2, 16'(k));
    wr_at_count(k, 3'd2, 16'(k + 2000));
    repeat (5) @(negedge clk);
    chk("R5 match suppressed", flags[0], 1'b0);

    // R10 set wins over coincident clear
    rd(3'd6, c1);
    k = int'(c1) + 40;
    wr(3'd2, 16'(k));
    wr_at_count(k, 3'd1, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R10 set beats clear", flags[0], 1'b1);
    wr(3'd1, 16'h000F);
    @(negedge clk);
    chk("R10 write one keeps", flags[0], 1'b1);
    wr(3'd1, 16'h0000);

    // R6-R9 measurement, rising start edge
    lim_wmax = 30; lim_wmin = 10; lim_pmax = 60;
    wr(3'd3, 16'(lim_wmax));
    wr(3'd4, 16'(lim_wmin));
    wr(3'd5, 16'(lim_pmax));
    wr(3'd0, 16'h0001);
    @(negedge clk); addr = 3'd7;
    act_lvl = 1'b1; have_prev = 0; exp_f = '0; pfx = "rising";
    pulse(20, 30);
    pulse(35, 20);
    pulse(5, 50);
    pulse(20, 50);
    pulse(20, 30);

    // R12 falling start edge
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    sig = 1'b1;
    repeat (6) @(negedge clk);
    wr(3'd0, 16'h0003);
    @(negedge clk); addr = 3'd7;
    act_lvl = 1'b0; have_prev = 0; exp_f = '0; pfx = "R12 falling";
    pulse(25, 30);
    pulse(40, 30);
    pulse(12, 20);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule